// File: doc/BRIEF.md
# Operand Effective-Address Generator

This block turns a memory-reference instruction into the address of its operand. A request carries the first instruction word, an optional second word, the address of the word that follows the instruction, and three index registers. The block decodes the format, the index selector and the indirection flag, and forms the address with a single adder. When indirection is requested it makes one read through a synchronous memory port and returns the word it reads as the result.

Requests arrive on a valid/ready input stream and results leave on a valid/ready output stream. The input is accepted on a cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low from acceptance until the result has been taken. A result offered with `ea_valid` holds its value, unchanged, until a cycle in which `ea_ready` is high. The memory read port has no handshake: read data must appear on `mem_rd_data` in the cycle after `mem_rd_en`.

Top module: `ea_gen`

## Requirements
- R1: After reset, `ea_valid` and `mem_rd_en` are low and `req_ready` is high.
- R2: Bit 10 of the first word (mask 0x0400) selects long format when set and short format when clear. In short format with selector bits [9:8] equal to 0, the result is `next_pc` plus bits [7:0] of the first word, sign-extended to 16 bits. The sum wraps modulo 2^16.
- R3: In short format with a selector value k of 1, 2 or 3, the result is index register k plus the sign-extended low byte, modulo 2^16. Register k occupies bits [16k-1:16(k-1)] of `idx_regs`.
- R4: In short format, bit 7 is only part of the displacement and never causes a memory read.
- R5: In long format with selector 0 and bit 7 clear, the result is `word1` unchanged.
- R6: In long format with a selector k of 1 to 3 and bit 7 clear, the result is `word1` plus index register k, modulo 2^16.
- R7: In long format with bit 7 set, `mem_rd_en` is high for exactly the accepting cycle. `mem_rd_addr` is then the address that R5 or R6 would give, and the result is the word returned from memory.
- R8: A non-indirect request raises `ea_valid` in the cycle after acceptance. An indirect request raises it two cycles after acceptance.
- R9: While `ea_valid` is high and `ea_ready` is low, `ea_valid` stays high, `ea_addr` stays unchanged and `req_ready` stays low. The cycle after `ea_ready` is seen high, `ea_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| word0 | input | 16 | First instruction word |
| word1 | input | 16 | Second instruction word (long format only) |
| next_pc | input | 16 | Address of the word after the instruction |
| idx_regs | input | 48 | Index registers 1..3, packed with register 1 in the low bits |
| mem_rd_en | output | 1 | Memory read strobe for indirection |
| mem_rd_addr | output | 16 | Memory read address |
| mem_rd_data | input | 16 | Memory read data, valid one cycle after the strobe |
| ea_valid | output | 1 | Effective address available |
| ea_ready | input | 1 | Consumer takes the address |
| ea_addr | output | 16 | Effective address |

## Verification
The assertions assume that the request fields are stable during the cycle in which `req_valid` is high. They also assume that the memory answers every strobe in the very next cycle. The consumer may hold `ea_ready` low for any length of time. The bench drives each request for exactly one accepting cycle and then removes it, and its memory model registers data on each strobe. It holds `ea_ready` low for zero to three cycles per transaction, so stalls appear both with and without indirection.

// File: rtl/ea_gen_pkg.sv
package ea_gen_pkg;
  localparam int LONG_BIT = 10;
  localparam int TAG_LSB  = 8;
  localparam int TAG_W    = 2;
  localparam int IND_BIT  = 7;
  localparam int DISP_W   = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MEM  = 2'd1,
    ST_HOLD = 2'd2
  } ea_state_e;
endpackage

// File: rtl/ea_gen_decode.sv
module ea_gen_decode
  import ea_gen_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] word0,
  output logic              is_long,
  output logic [TAG_W-1:0]  tag,
  output logic              indirect,
  output logic [ADDR_W-1:0] disp_ext
);
  localparam int EXT_W = ADDR_W - DISP_W;

  logic [DISP_W-1:0] disp;
  logic              unused_hi;

  assign is_long  = word0[LONG_BIT];
  assign tag      = word0[TAG_LSB +: TAG_W];
  assign disp     = word0[DISP_W-1:0];
  // bit 7 doubles as displacement sign in short format; only long honours it
  assign indirect = is_long & word0[IND_BIT];
  assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
  assign unused_hi = ^word0[ADDR_W-1:LONG_BIT+1];
endmodule

// File: rtl/ea_gen_calc.sv
module ea_gen_calc
  import ea_gen_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int NUM_XR = 3
) (
  input  logic                     is_long,
  input  logic [TAG_W-1:0]         tag,
  input  logic [ADDR_W-1:0]        disp_ext,
  input  logic [ADDR_W-1:0]        word1,
  input  logic [ADDR_W-1:0]        next_pc,
  input  logic [NUM_XR*ADDR_W-1:0] idx_regs,
  output logic [ADDR_W-1:0]        addr
);
  logic [ADDR_W-1:0] xr_arr [NUM_XR];
  logic [ADDR_W-1:0] xr_sel;
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] offset;

  for (genvar g = 0; g < NUM_XR; g++) begin : g_unpack
    assign xr_arr[g] = idx_regs[g*ADDR_W +: ADDR_W];
  end

  always_comb begin
    xr_sel = '0;
    for (int i = 0; i < NUM_XR; i++) begin
      if (int'(tag) == i + 1) xr_sel = xr_arr[i];
    end
  end

  // one adder: short = (pc | xr) + disp, long = word1 + (0 | xr)
  always_comb begin
    if (is_long) begin
      base   = word1;
      offset = (tag == '0) ? '0 : xr_sel;
    end else begin
      base   = (tag == '0) ? next_pc : xr_sel;
      offset = disp_ext;
    end
  end

  assign addr = base + offset;
endmodule

// File: rtl/ea_gen_ctrl.sv
module ea_gen_ctrl
  import ea_gen_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              indirect,
  input  logic [ADDR_W-1:0] calc_addr,
  input  logic [ADDR_W-1:0] mem_rd_data,
  input  logic              ea_ready,
  output logic              req_ready,
  output logic              mem_rd_en,
  output logic              ea_valid,
  output logic [ADDR_W-1:0] ea_addr
);
  ea_state_e         state_q, state_d;
  logic [ADDR_W-1:0] ea_q, ea_d;
  logic              accept;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid & req_ready;
  assign mem_rd_en = accept & indirect;
  assign ea_valid  = (state_q == ST_HOLD);
  assign ea_addr   = ea_q;

  always_comb begin
    state_d = state_q;
    ea_d    = ea_q;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (indirect) begin
            state_d = ST_MEM;
          end else begin
            state_d = ST_HOLD;
            ea_d    = calc_addr;
          end
        end
      end
      ST_MEM: begin
        state_d = ST_HOLD;
        ea_d    = mem_rd_data;
      end
      ST_HOLD: begin
        if (ea_ready) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ea_q    <= '0;
    end else begin
      state_q <= state_d;
      ea_q    <= ea_d;
    end
  end
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_gen_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int NUM_XR = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [ADDR_W-1:0]        word0,
  input  logic [ADDR_W-1:0]        word1,
  input  logic [ADDR_W-1:0]        next_pc,
  input  logic [NUM_XR*ADDR_W-1:0] idx_regs,
  output logic                     mem_rd_en,
  output logic [ADDR_W-1:0]        mem_rd_addr,
  input  logic [ADDR_W-1:0]        mem_rd_data,
  output logic                     ea_valid,
  input  logic                     ea_ready,
  output logic [ADDR_W-1:0]        ea_addr
);
  logic              is_long;
  logic [TAG_W-1:0]  tag;
  logic              indirect;
  logic [ADDR_W-1:0] disp_ext;
  logic [ADDR_W-1:0] calc_addr;

  ea_gen_decode #(.ADDR_W(ADDR_W)) u_decode (
    .word0    (word0),
    .is_long  (is_long),
    .tag      (tag),
    .indirect (indirect),
    .disp_ext (disp_ext)
  );

  ea_gen_calc #(.ADDR_W(ADDR_W), .NUM_XR(NUM_XR)) u_calc (
    .is_long  (is_long),
    .tag      (tag),
    .disp_ext (disp_ext),
    .word1    (word1),
    .next_pc  (next_pc),
    .idx_regs (idx_regs),
    .addr     (calc_addr)
  );

  ea_gen_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .indirect    (indirect),
    .calc_addr   (calc_addr),
    .mem_rd_data (mem_rd_data),
    .ea_ready    (ea_ready),
    .req_ready   (req_ready),
    .mem_rd_en   (mem_rd_en),
    .ea_valid    (ea_valid),
    .ea_addr     (ea_addr)
  );

  assign mem_rd_addr = calc_addr;
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] word0,
  input logic [ADDR_W-1:0] word1,
  input logic              mem_rd_en,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic              ea_valid,
  input logic              ea_ready,
  input logic [ADDR_W-1:0] ea_addr
);
  logic acc;
  assign acc = req_valid & req_ready;

  assert_reset_idle_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> !ea_valid && req_ready && !mem_rd_en);

  assert_long_tag0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && word0[10] && !word0[7] && word0[9:8] == 2'd0) |=> ea_addr == $past(word1));

  assert_short_no_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !word0[10]) |-> !mem_rd_en);

  assert_read_only_on_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> acc && word0[10] && word0[7]);

  assert_read_addr_long0_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && word0[9:8] == 2'd0) |-> mem_rd_addr == word1);

  assert_direct_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !(word0[10] && word0[7])) |=> ea_valid);

  assert_indirect_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !ea_valid ##1 ea_valid);

  assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ea_valid && !ea_ready) |=> ea_valid && $stable(ea_addr));

  assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ea_valid |-> !req_ready);

  assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ea_valid && ea_ready) |=> !ea_valid);
endmodule

bind ea_gen ea_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .word0       (word0),
  .word1       (word1),
  .mem_rd_en   (mem_rd_en),
  .mem_rd_addr (mem_rd_addr),
  .ea_valid    (ea_valid),
  .ea_ready    (ea_ready),
  .ea_addr     (ea_addr)
);

// File: tb/ea_gen_test.sv
`timescale 1ns/1ps
module ea_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] word0 = '0, word1 = '0, next_pc = '0;
  logic [47:0] idx_regs = '0;
  logic        mem_rd_en;
  logic [15:0] mem_rd_addr;
  logic [15:0] mem_rd_data = '0;
  logic        ea_valid;
  logic        ea_ready = 1'b0;
  logic [15:0] ea_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ea_gen uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .word0(word0), .word1(word1), .next_pc(next_pc), .idx_regs(idx_regs),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .ea_valid(ea_valid), .ea_ready(ea_ready), .ea_addr(ea_addr)
  );

  function automatic logic [15:0] mem_word(input logic [15:0] a);
    return (a * 16'h9E37) ^ 16'h5A5A;
  endfunction

  always_ff @(posedge clk) if (mem_rd_en) mem_rd_data <= mem_word(mem_rd_addr);

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic txn(input logic [15:0] w0, input logic [15:0] w1,
                     input logic [15:0] pc, input logic [47:0] xr, input int hold);
    bit          lng = w0[10];
    logic [1:0]  tg  = w0[9:8];
    bit          ind = lng & w0[7];
    logic [15:0] xv  = (tg == 0) ? 16'h0 : xr[(int'(tg)-1)*16 +: 16];
    logic [15:0] sx  = {{8{w0[7]}}, w0[7:0]};
    logic [15:0] dir, exp_ea;
    string       tagname;
    int          lat;
    if (!lng) dir = ((tg == 0) ? pc : xv) + sx;
    else      dir = w1 + xv;
    exp_ea = ind ? mem_word(dir) : dir;
    tagname = !lng ? ((tg == 0) ? "R2" : "R3") : (ind ? "R7" : ((tg == 0) ? "R5" : "R6"));
    @(negedge clk);
    word0 = w0; word1 = w1; next_pc = pc; idx_regs = xr;
    req_valid = 1'b1; ea_ready = 1'b0;
    #1;
    check(req_ready == 1'b1, "R9", {31'b0, req_ready}, 32'd1);
    if (!lng) check(mem_rd_en == 1'b0, "R4", {31'b0, mem_rd_en}, 32'd0);
    else      check(mem_rd_en == ind, "R7", {31'b0, mem_rd_en}, {31'b0, ind});
    if (ind) check(mem_rd_addr == dir, "R7", {16'b0, mem_rd_addr}, {16'b0, dir});
    @(negedge clk);
    req_valid = 1'b0;
    word0 = 16'hFFFF; word1 = 16'h1234;
    lat = 1;
    while (!ea_valid && lat < 5) begin
      check(mem_rd_en == 1'b0, "R7", {31'b0, mem_rd_en}, 32'd0);
      @(negedge clk);
      lat++;
    end
    check(lat == (ind ? 2 : 1), "R8", lat, ind ? 2 : 1);
    check(ea_addr == exp_ea, tagname, {16'b0, ea_addr}, {16'b0, exp_ea});
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check(ea_valid && ea_addr == exp_ea && !req_ready, "R9",
            {15'b0, ea_valid, ea_addr}, {15'b0, 1'b1, exp_ea});
    end
    ea_ready = 1'b1;
    @(negedge clk);
    ea_ready = 1'b0;
    check(ea_valid == 1'b0 && req_ready, "R9", {30'b0, ea_valid, req_ready}, 32'd1);
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [15:0] pcs [4] = '{16'h0100, 16'hFFFF, 16'h0000, 16'h7FF0};
    logic [7:0]  dsp [4] = '{8'h05, 8'h7F, 8'h80, 8'hFF};
    logic [47:0] xrs [4] = '{48'h3000_2000_1000, 48'hFFFF_8000_0001,
                             48'h0010_FFF0_7FFF, 48'hABCD_1357_FFFE};
    logic [15:0] w1s [4] = '{16'h0400, 16'hFFFF, 16'h8001, 16'h0000};
    repeat (3) @(negedge clk);
    // R1: reset state while reset is held
    check(!ea_valid && req_ready && !mem_rd_en, "R1",
          {29'b0, ea_valid, req_ready, mem_rd_en}, 32'd2);
    rst_n = 1'b1;
    @(negedge clk);
    check(!ea_valid && req_ready && !mem_rd_en, "R1",
          {29'b0, ea_valid, req_ready, mem_rd_en}, 32'd2);
    for (int p = 0; p < 4; p++) begin
      for (int lng = 0; lng < 2; lng++) begin
        for (int tg = 0; tg < 4; tg++) begin
          for (int ind = 0; ind < 2; ind++) begin
            logic [15:0] w0;
            logic [7:0]  d = dsp[p];
            // short format: bit 7 is displacement sign (R4); long: indirect flag
            if (lng == 0) d[7] = ind[0];
            else          d[7] = ind[0];
            w0 = {5'b10011, lng[0], tg[1:0], d};
            txn(w0, w1s[p], pcs[p], xrs[p], (p + tg + ind) % 4);
          end
        end
      end
    end
    done = 1;
    finish_run();
  end
endmodule